// File: doc/BRIEF.md
# Dual-Rail Four-Phase Full-Buffer Stage

This block is a one-bit pipeline stage that moves tokens between two dual-rail channels under four-phase return-to-zero handshaking. Each channel carries a value on a pair of rails, a true rail and a false rail. A token is present only when exactly one rail of the pair is high. The upstream channel enters on `in_t`/`in_f`, and the stage answers on `in_ack`. The downstream channel leaves on `out_t`/`out_f`, and the receiver answers on `out_ack`.

Inside, the stage is built from five small functions. Two detectors report when the input holds a token and when the output holds one. The output generator copies the input value onto the output rails. An acknowledge generator closes the input handshake, and an enable gates the next evaluation. All rails are level signals, sampled on a simulation clock. Output and input are handshaken independently, so the stage works as a full buffer. It can close the input handshake while its own output still waits for the receiver.

Top module: `dr_full_buffer`

## Requirements
- R1: After reset, `out_t`, `out_f` and `in_ack` are low, and the stage is empty: the first legal token is accepted without any earlier handshake.
- R2: Rails (t,f)=(0,1) carry 0, (1,0) carry 1, and (0,0) is neutral. Each input token appears on the output rails with the same value.
- R3: The output rail pair never reaches (1,1).
- R4: An input pair of (0,0) or (1,1) is not a token. While it is present, `in_ack` stays low and the output stays neutral.
- R5: `in_ack` rises only after the output has been driven valid with the current token. Once high, it stays high while the input stays valid.
- R6: `in_ack` falls on the first clock edge after the input returns to neutral.
- R7: A valid output holds its value until `out_ack` is high, and then returns to neutral.
- R8: The output does not become valid while `out_ack` is still high. It also does not become valid before the `in_ack` of the previous token has fallen.
- R9: The input handshake completes even while the output waits for its acknowledge. A further input token then stays unacknowledged, and the held output stays unchanged, until the output has been released.
- R10: Each input token produces exactly one output token, however long the sender keeps the input valid after `in_ack` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_t | input | 1 | Input true rail |
| in_f | input | 1 | Input false rail |
| in_ack | output | 1 | Acknowledge to the sender |
| out_t | output | 1 | Output true rail |
| out_f | output | 1 | Output false rail |
| out_ack | input | 1 | Acknowledge from the receiver |

## Verification
The bench runs three cases against a slow receiver:
- A second token that arrives while the output is still unacknowledged. A design without the full-buffer split would deadlock here, or it would overwrite the held value.
- A sender that keeps its token valid long after the acknowledge. A design with a wrong enable would emit a duplicate token, and the scoreboard finds no expected item for it.
- A receiver that keeps `out_ack` high after the output has cleared. A design that ignores this would launch the next token too early and the data would be lost.

The bench also drives the illegal (1,1) input code. A design that treats it as a token would acknowledge it.

// File: rtl/dr_full_buffer.sv
module dr_full_buffer (
  input  logic clk,
  input  logic rst_n,
  input  logic in_t,
  input  logic in_f,
  output logic in_ack,
  output logic out_t,
  output logic out_f,
  input  logic out_ack
);

  logic in_valid;
  logic out_valid;
  logic en;
  logic held;
  logic fire;

  assign in_valid  = in_t ^ in_f;
  assign out_valid = out_t | out_f;
  assign fire      = en & ~held & in_valid & ~out_valid & ~out_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_t <= 1'b0;
      out_f <= 1'b0;
    end else if (fire) begin
      out_t <= in_t;
      out_f <= in_f;
    end else if (out_valid && out_ack) begin
      out_t <= 1'b0;
      out_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      in_ack <= 1'b0;
    end else if (fire) begin
      held <= 1'b1;
    end else if (held) begin
      held   <= 1'b0;
      in_ack <= 1'b1;
    end else if (in_ack && !in_valid) begin
      in_ack <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      en <= 1'b1;
    else if (held)
      en <= 1'b0;
    else if (!en && !in_ack)
      en <= 1'b1;
  end

endmodule

// File: rtl/dr_full_buffer_chk.sv
module dr_full_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_t,
  input logic in_f,
  input logic in_ack,
  input logic out_t,
  input logic out_f,
  input logic out_ack
);

  // R3
  no_illegal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_t && out_f));

  // R2
  value_t_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_t) |-> ($past(in_t) && !$past(in_f)));

  // R2
  value_f_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_f) |-> ($past(in_f) && !$past(in_t)));

  // R5
  ack_after_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(out_t || out_f));

  // R5
  ack_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && (in_t ^ in_f)) |=> in_ack);

  // R6
  ack_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !in_t && !in_f) |=> !in_ack);

  // R7
  out_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_t || out_f) && !out_ack) |=> ($stable(out_t) && $stable(out_f)));

  // R8
  no_launch_under_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_t) || $rose(out_f)) |-> (!$past(out_ack) && !$past(in_ack)));

  // R4
  illegal_in_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_t && in_f && !in_ack) |=> !in_ack);

endmodule

bind dr_full_buffer dr_full_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
  .in_ack(in_ack), .out_t(out_t), .out_f(out_f), .out_ack(out_ack)
);

// File: tb/sim_dr_full_buffer.sv
module sim_dr_full_buffer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_t = 1'b0;
  logic in_f = 1'b0;
  logic out_ack = 1'b0;
  logic in_ack, out_t, out_f;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  bit exp_q[$];
  int sent = 0, out_cnt = 0, rise_cnt = 0, fall_cnt = 0;
  int rx_delay = 0, rx_tail = 0, wait_cnt = 0, tail_cnt = 0;
  logic prev_ack = 1'b0, prev_vt = 1'b0;
  logic [1:0] prev_rails = 2'b00;

  always #10 clk = ~clk;

  dr_full_buffer u0 (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
    .in_ack(in_ack), .out_t(out_t), .out_f(out_f), .out_ack(out_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor and receiver, sampled and driven on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      logic vt;
      vt = out_t | out_f;
      if (out_t && out_f) check(0, "R3", 3, 0);
      if (vt && !prev_vt) begin
        check(out_ack == 1'b0, "R8", out_ack, 0);
        check(fall_cnt == out_cnt, "R8", fall_cnt, out_cnt);
        if (exp_q.size() == 0) check(0, "R10", out_cnt + 1, sent);
        else begin
          bit e;
          e = exp_q.pop_front();
          check({out_t, out_f} == (e ? 2'b10 : 2'b01), "R2", {out_t, out_f}, e ? 2 : 1);
        end
        out_cnt++;
      end
      if (vt && prev_vt && !prev_ack)
        check({out_t, out_f} == prev_rails, "R7", {out_t, out_f}, prev_rails);
      if (in_ack && !prev_ack) begin
        check(out_cnt > rise_cnt, "R5", out_cnt, rise_cnt + 1);
        rise_cnt++;
      end
      if (!in_ack && prev_ack) fall_cnt++;
      prev_ack = in_ack;
      prev_vt = vt;
      prev_rails = {out_t, out_f};
      if (vt && !out_ack) begin
        if (wait_cnt >= rx_delay) begin out_ack = 1'b1; wait_cnt = 0; end
        else wait_cnt++;
      end else if (!vt && out_ack) begin
        if (tail_cnt >= rx_tail) begin out_ack = 1'b0; tail_cnt = 0; end
        else tail_cnt++;
      end
    end
  end

  task automatic send(input bit b, input int hold);
    @(negedge clk);
    in_t = b; in_f = ~b;
    exp_q.push_back(b);
    sent++;
    while (!in_ack) @(negedge clk);
    repeat (hold) begin
      @(negedge clk);
      check(in_ack == 1'b1, "R5", in_ack, 1);
    end
    in_t = 1'b0; in_f = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R6", in_ack, 0);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || out_t || out_f || out_ack) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_t, out_f, in_ack} == 3'b000, "R1", {out_t, out_f, in_ack}, 0);
    mon_on = 1'b1;

    // R1: first token accepted right away
    send(1'b1, 0);
    drain();
    check(out_cnt == 1, "R1", out_cnt, 1);

    // R4: illegal and neutral codes are not tokens
    @(negedge clk);
    in_t = 1'b1; in_f = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(in_ack == 1'b0 && !out_t && !out_f, "R4", {in_ack, out_t, out_f}, 0);
    end
    in_t = 1'b0; in_f = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(in_ack == 1'b0 && !out_t && !out_f, "R4", {in_ack, out_t, out_f}, 0);
    end

    // R9: slow receiver, second token waits
    rx_delay = 25;
    send(1'b0, 0);
    check(out_f == 1'b1 && out_t == 1'b0, "R9", {out_t, out_f}, 1);
    @(negedge clk);
    in_t = 1'b1; in_f = 1'b0;
    exp_q.push_back(1'b1);
    sent++;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(in_ack == 1'b0 && out_f && !out_t, "R9", {in_ack, out_t, out_f}, 1);
    end
    while (!in_ack) @(negedge clk);
    in_t = 1'b0; in_f = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R6", in_ack, 0);
    rx_delay = 0;
    drain();

    // R10: sender holds token long after the acknowledge
    send(1'b1, 15);
    send(1'b0, 12);
    drain();

    // R8: receiver keeps its acknowledge high after the output clears
    rx_tail = 6;
    send(1'b0, 0);
    send(1'b1, 0);
    send(1'b1, 0);
    drain();
    rx_tail = 0;

    // R2: mixed stream with varied pacing
    for (int i = 0; i < 40; i++) begin
      rx_delay = (i * 3) % 5;
      rx_tail = i % 3;
      send(((i * 7 + 3) % 5) > 2, i % 4);
    end
    rx_tail = 0;
    drain();
    check(out_cnt == sent, "R10", out_cnt, sent);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

endmodule